// File: doc/BRIEF.md
# Wide-to-narrow register bus bridge

The bridge sits between a wide processor-side register port and a narrow register bus that reaches the peripheral registers. The processor side carries a word of `CPU_DW` bits. The register bus carries `CSR_DW` bits per access, and `CPU_DW` is a power-of-two multiple of `CSR_DW` that is at least 2. Every processor read or write is split into `RATIO = CPU_DW/CSR_DW` narrow accesses. These accesses are issued back to back at consecutive narrow addresses, lowest chunk first.

A read collects one narrow result per chunk. Each result is sampled in the cycle after its strobe, and the results are joined into one wide word. A write hands out the wide data one chunk per strobe. The full set of chunks is always issued. This lets downstream registers capture their whole value on the first chunk of a read and commit on the last chunk of a write, so multi-chunk registers are accessed atomically.

The processor holds `cpu_req` high until it sees the one-cycle `cpu_ack`. A request is taken only while the bridge is idle.

Top module: `csr_width_bridge`

## Requirements
- R1: Each accepted request produces exactly RATIO narrow strobes. A request with `cpu_we`=0 produces only `csr_r_stb` pulses, and a request with `cpu_we`=1 produces only `csr_w_stb` pulses.
- R2: During strobe k of a request, where k counts from 0 up to RATIO-1 in order, `csr_addr` equals `{cpu_addr, k}`. That is the word address shifted left by log2(RATIO), plus k.
- R3: In the same cycle as write strobe k, `csr_w_data` equals `cpu_wdata[k*CSR_DW +: CSR_DW]`.
- R4: Chunk k of a read result is the value of `csr_r_data` in the cycle after read strobe k, placed at bits `[k*CSR_DW +: CSR_DW]`. A zero returned by the bus, for example from an unmapped address, appears unchanged as zero.
- R5: Suppose the request is seen in idle cycle c. The strobes then occupy cycles c+1 to c+RATIO, and `cpu_ack` is high for exactly one cycle, c+RATIO+1. During that cycle `cpu_rdata` carries the assembled read word.
- R6: `csr_r_stb` and `csr_w_stb` are never high together. Changes to `cpu_addr`, `cpu_wdata` and `cpu_we` after a request has been accepted do not affect that request.
- R7: While `rst_n` is low at a clock edge, the bridge goes idle and no strobe or acknowledge is driven. A request cut short by reset issues no further strobes.
- R8: `cpu_rdata` is zero in every cycle except the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Wide word address |
| cpu_wdata | input | CPU_DW | Wide write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | CPU_DW | Assembled read word, valid with cpu_ack |
| csr_addr | output | CPU_AW+log2(RATIO) | Narrow bus address |
| csr_r_stb | output | 1 | Narrow read strobe |
| csr_r_data | input | CSR_DW | Narrow read data, valid the cycle after csr_r_stb |
| csr_w_stb | output | 1 | Narrow write strobe |
| csr_w_data | output | CSR_DW | Narrow write data, valid with csr_w_stb |

## Verification
Some rules can be checked on every cycle by the assertions:
- the two strobes never overlap;
- the chunk address starts at zero and climbs by one within a burst;
- the acknowledge is a single pulse that follows a strobe;
- the read port stays zero outside the acknowledge;
- reset silences the outputs.

Other rules can only be shown by the bench's scenarios. These cover the exact number of strobes per request, the mapping of wide data bits onto each write chunk, the assembly of read chunks against a bus model that answers one cycle late (including an unmapped region that answers zero), immunity to inputs changing mid-request, and abandonment of a request on reset.

// File: rtl/csr_width_bridge_pkg.sv
// Package: types shared by the wide-to-narrow register bridge.
// Assumes nothing beyond IEEE 1800-2017 enums.
package csr_width_bridge_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // waiting for a request
        SEQ_RUN  = 2'd1,   // issuing one narrow strobe per cycle
        SEQ_FIN  = 2'd2    // acknowledge cycle, last read chunk on the bus
    } seq_state_t;
endpackage

// File: rtl/csr_wb_seq.sv
// Module: csr_wb_seq
// Sequences one wide request into RATIO strobe cycles followed by one
// acknowledge cycle. Assumes RATIO is a power of two, at least 2, and
// that rst_n is synchronous and active low.
module csr_wb_seq
    import csr_width_bridge_pkg::*;
#(
    parameter int RATIO = 4,
    localparam int CW = $clog2(RATIO)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    output logic          accept,
    output logic          run,
    output logic          fin,
    output logic [CW-1:0] chunk
);
    localparam logic [CW-1:0] LAST_CHUNK = CW'(RATIO - 1);

    seq_state_t state_q;

    // Purpose: state and chunk counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            chunk   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    chunk <= '0;
                    if (cpu_req) state_q <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (chunk == LAST_CHUNK) begin
                        state_q <= SEQ_FIN;
                        chunk   <= '0;
                    end else begin
                        chunk <= chunk + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: decode the phase flags from the state.
    always_comb begin
        accept = (state_q == SEQ_IDLE) && cpu_req;
        run    = (state_q == SEQ_RUN);
        fin    = (state_q == SEQ_FIN);
    end
endmodule

// File: rtl/csr_wb_wslice.sv
// Module: csr_wb_wslice
// Selects the narrow write chunk addressed by the chunk counter from
// the captured wide write word. Assumes RATIO is a power of two, so
// every counter value names a chunk.
module csr_wb_wslice #(
    parameter int N     = 8,
    parameter int RATIO = 4,
    localparam int CW = $clog2(RATIO)
) (
    input  logic [N*RATIO-1:0] wide,
    input  logic [CW-1:0]      chunk,
    output logic [N-1:0]       narrow
);
    logic [N-1:0] pieces [RATIO];

    for (genvar i = 0; i < RATIO; i++) begin : g_piece
        assign pieces[i] = wide[i*N +: N];
    end

    // Purpose: pick the current chunk.
    always_comb narrow = pieces[chunk];
endmodule

// File: rtl/csr_wb_rasm.sv
// Module: csr_wb_rasm
// Collects narrow read results into a wide word. The result of a strobe
// is sampled in the following cycle. The lower RATIO-1 chunks are held in
// registers, and the top chunk is taken live from the bus during the
// presentation cycle. Assumes the bus returns data exactly one cycle
// after each strobe.
module csr_wb_rasm #(
    parameter int N     = 8,
    parameter int RATIO = 4,
    localparam int CW = $clog2(RATIO)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               r_stb,
    input  logic [CW-1:0]      chunk,
    input  logic [N-1:0]       r_data,
    input  logic               present,
    output logic [N*RATIO-1:0] word
);
    logic                   pend_q;
    logic [CW-1:0]          pidx_q;
    logic [N*(RATIO-1)-1:0] low;

    // Purpose: remember which chunk's data arrives next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pidx_q <= '0;
        end else begin
            pend_q <= r_stb;
            pidx_q <= chunk;
        end
    end

    for (genvar i = 0; i < RATIO - 1; i++) begin : g_hold
        logic [N-1:0] hold_q;
        // Purpose: capture chunk i one cycle after its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                           hold_q <= '0;
            else if (pend_q && pidx_q == CW'(i))  hold_q <= r_data;
        end
        assign low[i*N +: N] = hold_q;
    end

    // Purpose: present the joined word only in the acknowledge cycle.
    always_comb word = present ? {r_data, low} : '0;
endmodule

// File: rtl/csr_width_bridge.sv
// Module: csr_width_bridge (top)
// Wide processor port to narrow register bus bridge. A request taken in
// idle becomes RATIO strobes at {word, chunk}, lowest chunk first, and
// then a one-cycle acknowledge. Assumes CPU_DW = RATIO*CSR_DW, with
// RATIO a power of two and at least 2, and a bus that answers reads one
// cycle late and reads zero when idle.
module csr_width_bridge
    import csr_width_bridge_pkg::*;
#(
    parameter int CPU_DW = 32,
    parameter int CSR_DW = 8,
    parameter int CPU_AW = 8,
    localparam int RATIO  = CPU_DW / CSR_DW,
    localparam int CW     = $clog2(RATIO),
    localparam int CSR_AW = CPU_AW + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic [CSR_AW-1:0] csr_addr,
    output logic              csr_r_stb,
    input  logic [CSR_DW-1:0] csr_r_data,
    output logic              csr_w_stb,
    output logic [CSR_DW-1:0] csr_w_data
);
    logic              accept, run, fin;
    logic [CW-1:0]     chunk;
    logic              we_q;
    logic [CPU_AW-1:0] word_q;
    logic [CPU_DW-1:0] wdata_q;

    csr_wb_seq #(.RATIO(RATIO)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .accept  (accept),
        .run     (run),
        .fin     (fin),
        .chunk   (chunk)
    );

    // Purpose: freeze the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            word_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= cpu_we;
            word_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end

    // Purpose: drive the narrow bus controls and the acknowledge.
    always_comb begin
        csr_addr  = {word_q, chunk};
        csr_r_stb = run && !we_q;
        csr_w_stb = run && we_q;
        cpu_ack   = fin;
    end

    csr_wb_wslice #(.N(CSR_DW), .RATIO(RATIO)) u_wslice (
        .wide   (wdata_q),
        .chunk  (chunk),
        .narrow (csr_w_data)
    );

    csr_wb_rasm #(.N(CSR_DW), .RATIO(RATIO)) u_rasm (
        .clk     (clk),
        .rst_n   (rst_n),
        .r_stb   (csr_r_stb),
        .chunk   (chunk),
        .r_data  (csr_r_data),
        .present (fin && !we_q),
        .word    (cpu_rdata)
    );
endmodule

// File: rtl/csr_width_bridge_chk.sv
// Module: csr_width_bridge_chk
// Cycle-by-cycle protocol checks for csr_width_bridge, attached by bind.
// Assumes the same parameters as the bridge it watches.
module csr_width_bridge_chk #(
    parameter int CPU_DW = 32,
    parameter int CSR_AW = 10,
    parameter int CW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ack,
    input logic [CPU_DW-1:0] cpu_rdata,
    input logic [CSR_AW-1:0] csr_addr,
    input logic              csr_r_stb,
    input logic              csr_w_stb
);
    logic stb;
    always_comb stb = csr_r_stb || csr_w_stb;

    // R6: the two strobe kinds never overlap.
    p_excl_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_r_stb && csr_w_stb));

    // R2: a burst starts at chunk 0.
    p_burst_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |-> (csr_addr[CW-1:0] == '0));

    // R2: consecutive strobes step the address by one.
    p_chunk_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && $past(stb)) |-> (csr_addr == $past(csr_addr) + 1'b1));

    // R5: the acknowledge lasts one cycle.
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R5: the acknowledge follows directly after a strobe.
    p_ack_after_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> $past(stb));

    // R8: read data stays zero outside the acknowledge.
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |-> (cpu_rdata == '0));

    // R7: reset silences strobes and acknowledge.
    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> (!csr_r_stb && !csr_w_stb && !cpu_ack));
endmodule

bind csr_width_bridge csr_width_bridge_chk #(
    .CPU_DW (CPU_DW),
    .CSR_AW (CSR_AW),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .csr_addr  (csr_addr),
    .csr_r_stb (csr_r_stb),
    .csr_w_stb (csr_w_stb)
);

// File: tb/csr_width_bridge_test.sv
`timescale 1ns/100ps
// Bench for csr_width_bridge: vector table walk, then directed cases.
module csr_width_bridge_test;
    localparam int KW = 32;
    localparam int NW = 8;
    localparam int AW = 8;
    localparam int R  = KW / NW;
    localparam int SAW = AW + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0]  cpu_addr = '0;
    logic [KW-1:0]  cpu_wdata = '0;
    logic           cpu_ack;
    logic [KW-1:0]  cpu_rdata;
    logic [SAW-1:0] csr_addr;
    logic           csr_r_stb, csr_w_stb;
    logic [NW-1:0]  csr_r_data, csr_w_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csr_width_bridge uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .csr_addr(csr_addr), .csr_r_stb(csr_r_stb),
        .csr_r_data(csr_r_data), .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data)
    );

    // Bus model content: the top quarter of the map is unmapped and reads zero.
    function automatic logic [NW-1:0] bus_val(input logic [SAW-1:0] a);
        if (a[SAW-1:SAW-2] == 2'b11) return '0;
        return a[7:0] ^ {a[9:8], 6'h2B};
    endfunction

    // Bus model: answers one cycle after the read strobe, zero when idle.
    logic [NW-1:0] bus_q = '0;
    always @(posedge clk) bus_q <= (rst_n && csr_r_stb) ? bus_val(csr_addr) : '0;
    assign csr_r_data = bus_q;

    // Strobe log, sampled away from the active edge.
    logic [SAW-1:0] la [256];
    logic [NW-1:0]  ld [256];
    logic           lk [256];
    int             ln = 0;
    always @(negedge clk) begin
        if (rst_n && (csr_r_stb || csr_w_stb)) begin
            la[ln[7:0]] <= csr_addr;
            ld[ln[7:0]] <= csr_w_data;
            lk[ln[7:0]] <= csr_w_stb;
            ln <= ln + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; optionally scramble inputs after acceptance.
    task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [KW-1:0] d,
                        input bit scramble, output logic [KW-1:0] rd, output int lat, output int start);
        @(negedge clk);
        start = ln;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        lat = 0; rd = '0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            lat++;
            if (scramble) begin
                cpu_we = ~we; cpu_addr = ~a; cpu_wdata = ~d;
            end
            if (cpu_ack) begin
                rd = cpu_rdata;
                break;
            end
        end
        cpu_req = 1'b0;
    endtask

    // Check strobe log contents for one request.
    task automatic check_log(input bit we, input logic [AW-1:0] a, input logic [KW-1:0] d, input int start);
        check(ln - start == R, "R1 strobe count", ln - start, R);
        for (int k = 0; k < R; k++) begin
            check(lk[(start+k)%256] == we, "R1 strobe kind", lk[(start+k)%256], we);
            check(la[(start+k)%256] == {a, 2'(k)}, "R2 chunk address", la[(start+k)%256], {a, 2'(k)});
            if (we) check(ld[(start+k)%256] == d[k*NW +: NW], "R3 write chunk",
                          ld[(start+k)%256], d[k*NW +: NW]);
        end
    endtask

    function automatic logic [KW-1:0] exp_word(input logic [AW-1:0] a);
        logic [KW-1:0] w;
        for (int k = 0; k < R; k++) w[k*NW +: NW] = bus_val({a, 2'(k)});
        return w;
    endfunction

    // {we, addr, data}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 8'h03, 32'hA1B2C3D4},
        {1'b0, 8'h03, 32'h0},
        {1'b0, 8'h00, 32'h0},
        {1'b1, 8'hFF, 32'h00000001},
        {1'b0, 8'hC5, 32'h0},
        {1'b1, 8'h5A, 32'hFFFFFFFF},
        {1'b0, 8'hBF, 32'h0},
        {1'b1, 8'h80, 32'h80000000}
    };

    initial begin
        logic [KW-1:0] rd;
        int lat, st;
        repeat (3) @(negedge clk);
        check(!cpu_ack && !csr_r_stb && !csr_w_stb, "R7 reset outputs quiet",
              {cpu_ack, csr_r_stb, csr_w_stb}, 0);
        check(cpu_rdata == '0, "R8 rdata zero in reset", cpu_rdata, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            xfer(VEC[v][40], VEC[v][39:32], VEC[v][31:0], 1'b0, rd, lat, st);
            check(lat == R + 1, "R5 ack latency", lat, R + 1);
            check_log(VEC[v][40], VEC[v][39:32], VEC[v][31:0], st);
            if (VEC[v][40]) check(rd == '0, "R8 rdata zero on write ack", rd, 0);
            else            check(rd == exp_word(VEC[v][39:32]), "R4 read word", rd, exp_word(VEC[v][39:32]));
            @(negedge clk);
            check(!cpu_ack, "R5 ack single cycle", cpu_ack, 0);
            check(cpu_rdata == '0, "R8 rdata zero when idle", cpu_rdata, 0);
        end

        // R4: unmapped region passes zero through.
        xfer(1'b0, 8'hE7, '0, 1'b0, rd, lat, st);
        check(rd == '0, "R4 unmapped reads zero", rd, 0);

        // R6: inputs changed after acceptance have no effect.
        xfer(1'b1, 8'h21, 32'h13579BDF, 1'b1, rd, lat, st);
        check_log(1'b1, 8'h21, 32'h13579BDF, st);
        xfer(1'b0, 8'h44, '0, 1'b1, rd, lat, st);
        check_log(1'b0, 8'h44, '0, st);
        check(rd == exp_word(8'h44), "R6 read unaffected by input change", rd, exp_word(8'h44));

        // R7: reset in the middle of a read abandons it.
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h12;
        repeat (2) @(negedge clk);
        cpu_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!csr_r_stb && !csr_w_stb && !cpu_ack, "R7 reset stops burst",
              {cpu_ack, csr_r_stb, csr_w_stb}, 0);
        rst_n = 1'b1;
        st = ln;
        repeat (8) @(negedge clk);
        check(ln == st, "R7 no strobes after abandoned request", ln - st, 0);
        xfer(1'b0, 8'h12, '0, 1'b0, rd, lat, st);
        check(lat == R + 1, "R5 latency after reset", lat, R + 1);
        check(rd == exp_word(8'h12), "R4 read after reset", rd, exp_word(8'h12));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule